// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer of 512 nine-bit words whose write side and read side run on unrelated clocks. Each side keeps its own binary pointer, publishes it to the other side in Gray code through a chain of synchronizer flops, and derives its status flags from its own pointer and the synchronized copy of the other one. The write side drives a full flag and an almost-full flag. The read side drives an empty flag and an almost-empty flag. All four flags are active low and come straight from flip-flops.

The almost-empty threshold n and the almost-full threshold m are held in two offset registers. Each register is split into a low part and a high part. The same input bus loads both words and thresholds. With the load-select input high, a write strobe stores a word. With load-select low, a write strobe loads the next offset part in a fixed four-step rotation. On the read port, the same rotation returns the offset parts when load-select is low, and returns stored words when it is high.

The offset registers are treated as static configuration. The almost-empty logic on the read side uses the empty offset without synchronizing it. Software is expected to load the offsets while the FIFO is idle.

Top module: `thresh_fifo`

## Requirements
- R1: With ld_n low and wr_en_n low, each rising wr_clk edge loads one offset part, in the rotation step 0 = empty-offset low part (wr_data[4:0] into n[4:0]), step 1 = empty-offset high part (wr_data[3:0] into n[8:5]), step 2 = full-offset low part (into m[4:0]), step 3 = full-offset high part (into m[8:5]). After step 3 the rotation returns to step 0. No word is stored.
- R2: With ld_n high, wr_en_n low and full_n high, a rising wr_clk edge stores wr_data as the newest word. While wr_en_n is high, no word is stored and no offset part changes, whatever the level of ld_n.
- R3: After reset, n = m = 7, both rotations stand at step 0, empty_n = 0, aempty_n = 0, full_n = 1, afull_n = 1 and rd_data = 0.
- R4: With ld_n high, rd_en_n low and empty_n high, a rising rd_clk edge removes the oldest word and presents it on rd_data from that edge onward. Words leave in the order they were written.
- R5: empty_n is low exactly when the read side sees 0 words. full_n is low exactly when the write side sees 512 words.
- R6: aempty_n is a rd_clk flop. It is low when the FIFO holds n or fewer words and high when it holds n+1 or more.
- R7: afull_n is a wr_clk flop. It is low when the FIFO holds 512−m or more words and high when more than m locations are free.
- R8: With ld_n low and rd_en_n low, each rising rd_clk edge puts the offset part at the read rotation step on rd_data, zero-extended, with the same step order and bit placement as R1. The rotation wraps after step 3, and the stored words are not disturbed.
- R9: A write strobe while full_n is low is ignored. The write pointer does not move and the word is never read out.
- R10: A read strobe while empty_n is low is ignored. The read pointer does not move and the next word written is the next word read.
- R11: Each pointer crosses to the other clock domain as Gray code through a two-flop synchronizer. A single write clears empty_n within four rising rd_clk edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ld_n | input | 1 | Load-select: high = data path, low = offset registers |
| wr_en_n | input | 1 | Active-low write strobe |
| wr_data | input | 9 | Word or offset part to write |
| full_n | output | 1 | Low when 512 words are held |
| afull_n | output | 1 | Low when 512−m or more words are held |
| rd_en_n | input | 1 | Active-low read strobe |
| rd_data | output | 9 | Word read, or offset part read back |
| empty_n | output | 1 | Low when no word is held |
| aempty_n | output | 1 | Low when n or fewer words are held |

## Verification
The assertions assume that ld_n, which both clock domains sample, only changes while both strobes are idle. They also assume the offsets are not reloaded while words are moving, because the read side uses the empty offset without a synchronizer. The bench holds ld_n high for the whole random phase and moves it only around directed programming and read-back steps. It loads offsets only while the FIFO is quiet. The random writer strobes only when full_n is high, and the random reader strobes only when empty_n is high, so the bench's model queue stays exact. The directed overflow and underflow steps then break this rule on purpose.

// File: rtl/tf_pkg.sv
package tf_pkg;

   // rotation position shared by the offset load and offset read-back paths
   typedef enum logic [1:0] {
      SEL_E_LO = 2'd0,
      SEL_E_HI = 2'd1,
      SEL_F_LO = 2'd2,
      SEL_F_HI = 2'd3
   } ofs_sel_e;

   function automatic ofs_sel_e next_sel(input ofs_sel_e s);
      return ofs_sel_e'(s + 2'd1);
   endfunction

   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/tf_sync.sv
module tf_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tf_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("tf_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/tf_mem.sv
module tf_mem #(
   parameter int DATA_W = 9,
   parameter int ADDR_W = 9
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rclk,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("tf_mem: ADDR_W out of supported range");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rclk) begin
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/tf_wr_ctrl.sv
module tf_wr_ctrl
   import tf_pkg::*;
#(
   parameter int DATA_W  = 9,
   parameter int ADDR_W  = 9,
   parameter int LO_W    = 5,
   parameter int DEF_OFS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_n,
   input  logic              ld_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W:0]   rgray_sync,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [ADDR_W:0]   wptr_bin,
   output logic [ADDR_W:0]   wptr_gray,
   output logic              full_n,
   output logic              afull_n,
   output logic [ADDR_W-1:0] ofs_e,
   output logic [ADDR_W-1:0] ofs_f,
   output logic [1:0]        step
);

   localparam int PTR_W = ADDR_W + 1;
   localparam int HI_W  = ADDR_W - LO_W;
   localparam logic [PTR_W-1:0]  DEPTH_P = {1'b1, {ADDR_W{1'b0}}};
   localparam logic [ADDR_W-1:0] DEF_V   = ADDR_W'(DEF_OFS);

   logic [LO_W-1:0]  e_lo, f_lo;
   logic [HI_W-1:0]  e_hi, f_hi;
   ofs_sel_e         sel;
   logic [PTR_W-1:0] wptr, wptr_nxt, rptr_b, cnt_nxt, af_lim;
   logic             full_q, afull_q, push, prog;

   assign push     = !wr_en_n && ld_n && full_q;
   assign prog     = !wr_en_n && !ld_n;
   assign wptr_nxt = wptr + PTR_W'(push);
   assign rptr_b   = PTR_W'(gray2bin(32'(rgray_sync)));
   assign cnt_nxt  = wptr_nxt - rptr_b;
   assign ofs_e    = {e_hi, e_lo};
   assign ofs_f    = {f_hi, f_lo};
   assign af_lim   = DEPTH_P - {1'b0, ofs_f};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr      <= '0;
         wptr_gray <= '0;
         full_q    <= 1'b1;
         afull_q   <= 1'b1;
      end else begin
         wptr      <= wptr_nxt;
         wptr_gray <= PTR_W'(bin2gray(32'(wptr_nxt)));
         full_q    <= (cnt_nxt != DEPTH_P);
         afull_q   <= (cnt_nxt < af_lim);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_lo <= DEF_V[LO_W-1:0];
         e_hi <= DEF_V[ADDR_W-1:LO_W];
         f_lo <= DEF_V[LO_W-1:0];
         f_hi <= DEF_V[ADDR_W-1:LO_W];
         sel  <= SEL_E_LO;
      end else if (prog) begin
         unique case (sel)
            SEL_E_LO: e_lo <= wr_data[LO_W-1:0];
            SEL_E_HI: e_hi <= wr_data[HI_W-1:0];
            SEL_F_LO: f_lo <= wr_data[LO_W-1:0];
            SEL_F_HI: f_hi <= wr_data[HI_W-1:0];
            default:  ;
         endcase
         sel <= next_sel(sel);
      end
   end

   assign mem_we    = push;
   assign mem_waddr = wptr[ADDR_W-1:0];
   assign wptr_bin  = wptr;
   assign full_n    = full_q;
   assign afull_n   = afull_q;
   assign step      = sel;

endmodule

// File: rtl/tf_rd_ctrl.sv
module tf_rd_ctrl
   import tf_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int ADDR_W = 9,
   parameter int LO_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_n,
   input  logic              ld_n,
   input  logic [ADDR_W:0]   wgray_sync,
   input  logic [ADDR_W-1:0] ofs_e,
   input  logic [ADDR_W-1:0] ofs_f,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic [ADDR_W:0]   rptr_bin,
   output logic [ADDR_W:0]   rptr_gray,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_n,
   output logic              aempty_n,
   output logic [1:0]        step
);

   localparam int PTR_W = ADDR_W + 1;
   localparam int HI_W  = ADDR_W - LO_W;

   ofs_sel_e          sel;
   logic [PTR_W-1:0]  rptr, rptr_nxt, wptr_b, cnt_nxt;
   logic              empty_q, aempty_q, pop, rback, src_rb;
   logic [DATA_W-1:0] part_ext, rb_q;

   assign pop      = !rd_en_n && ld_n && empty_q;
   assign rback    = !rd_en_n && !ld_n;
   assign rptr_nxt = rptr + PTR_W'(pop);
   assign wptr_b   = PTR_W'(gray2bin(32'(wgray_sync)));
   assign cnt_nxt  = wptr_b - rptr_nxt;

   always_comb begin
      part_ext = '0;
      unique case (sel)
         SEL_E_LO: part_ext[LO_W-1:0] = ofs_e[LO_W-1:0];
         SEL_E_HI: part_ext[HI_W-1:0] = ofs_e[ADDR_W-1:LO_W];
         SEL_F_LO: part_ext[LO_W-1:0] = ofs_f[LO_W-1:0];
         SEL_F_HI: part_ext[HI_W-1:0] = ofs_f[ADDR_W-1:LO_W];
         default:  part_ext = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr      <= '0;
         rptr_gray <= '0;
         empty_q   <= 1'b0;
         aempty_q  <= 1'b0;
      end else begin
         rptr      <= rptr_nxt;
         rptr_gray <= PTR_W'(bin2gray(32'(rptr_nxt)));
         empty_q   <= (cnt_nxt != '0);
         aempty_q  <= (cnt_nxt > {1'b0, ofs_e});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel    <= SEL_E_LO;
         rb_q   <= '0;
         src_rb <= 1'b1;
      end else if (rback) begin
         rb_q   <= part_ext;
         src_rb <= 1'b1;
         sel    <= next_sel(sel);
      end else if (pop) begin
         src_rb <= 1'b0;
      end
   end

   assign rd_data   = src_rb ? rb_q : mem_rdata;
   assign mem_re    = pop;
   assign mem_raddr = rptr[ADDR_W-1:0];
   assign rptr_bin  = rptr;
   assign empty_n   = empty_q;
   assign aempty_n  = aempty_q;
   assign step      = sel;

endmodule

// File: rtl/thresh_fifo.sv
module thresh_fifo #(
   parameter int DATA_W      = 9,
   parameter int ADDR_W      = 9,
   parameter int OFS_LO_W    = 5,
   parameter int DEF_OFS     = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              wr_en_n,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full_n,
   output logic              afull_n,
   input  logic              rd_en_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_n,
   output logic              aempty_n
);

   localparam int PTR_W    = ADDR_W + 1;
   localparam int OFS_HI_W = ADDR_W - OFS_LO_W;

   generate
      if (OFS_LO_W < 1 || OFS_HI_W < 1) begin : g_bad_split
         $error("thresh_fifo: offset split must leave both parts non-empty");
      end
      if (OFS_LO_W > DATA_W || OFS_HI_W > DATA_W) begin : g_bad_bus
         $error("thresh_fifo: an offset part is wider than the data bus");
      end
      if (DEF_OFS < 0 || DEF_OFS >= (1 << ADDR_W)) begin : g_bad_def
         $error("thresh_fifo: DEF_OFS out of range");
      end
   endgenerate

   logic              mem_we, mem_re;
   logic [ADDR_W-1:0] mem_waddr, mem_raddr;
   logic [DATA_W-1:0] mem_rdata;
   logic [PTR_W-1:0]  wr_ptr_bin, rd_ptr_bin, wr_ptr_gray, rd_ptr_gray;
   logic [PTR_W-1:0]  wgray_in_rd, rgray_in_wr;
   logic [ADDR_W-1:0] ofs_e, ofs_f;
   logic [1:0]        wr_step, rd_step;

   tf_wr_ctrl #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .LO_W   (OFS_LO_W),
      .DEF_OFS(DEF_OFS)
   ) u_wr (
      .clk       (wr_clk),
      .rst_n     (rst_n),
      .wr_en_n   (wr_en_n),
      .ld_n      (ld_n),
      .wr_data   (wr_data),
      .rgray_sync(rgray_in_wr),
      .mem_we    (mem_we),
      .mem_waddr (mem_waddr),
      .wptr_bin  (wr_ptr_bin),
      .wptr_gray (wr_ptr_gray),
      .full_n    (full_n),
      .afull_n   (afull_n),
      .ofs_e     (ofs_e),
      .ofs_f     (ofs_f),
      .step      (wr_step)
   );

   tf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk  (rd_clk),
      .rst_n(rst_n),
      .d    (wr_ptr_gray),
      .q    (wgray_in_rd)
   );

   tf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk  (wr_clk),
      .rst_n(rst_n),
      .d    (rd_ptr_gray),
      .q    (rgray_in_wr)
   );

   tf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .wclk (wr_clk),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(wr_data),
      .rclk (rd_clk),
      .re   (mem_re),
      .raddr(mem_raddr),
      .rdata(mem_rdata)
   );

   tf_rd_ctrl #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W),
      .LO_W  (OFS_LO_W)
   ) u_rd (
      .clk       (rd_clk),
      .rst_n     (rst_n),
      .rd_en_n   (rd_en_n),
      .ld_n      (ld_n),
      .wgray_sync(wgray_in_rd),
      .ofs_e     (ofs_e),
      .ofs_f     (ofs_f),
      .mem_rdata (mem_rdata),
      .mem_re    (mem_re),
      .mem_raddr (mem_raddr),
      .rptr_bin  (rd_ptr_bin),
      .rptr_gray (rd_ptr_gray),
      .rd_data   (rd_data),
      .empty_n   (empty_n),
      .aempty_n  (aempty_n),
      .step      (rd_step)
   );

endmodule

// File: rtl/thresh_fifo_chk.sv
module thresh_fifo_chk #(
   parameter int PTR_W = 10
) (
   input logic             wr_clk,
   input logic             rd_clk,
   input logic             rst_n,
   input logic             ld_n,
   input logic             wr_en_n,
   input logic             rd_en_n,
   input logic             full_n,
   input logic             afull_n,
   input logic             empty_n,
   input logic             aempty_n,
   input logic [PTR_W-1:0] wr_ptr,
   input logic [PTR_W-1:0] rd_ptr,
   input logic [1:0]       wr_step,
   input logic [1:0]       rd_step
);

   // R1: an offset load advances the rotation and stores no word
   a_r1_step_advance: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!ld_n && !wr_en_n) |=> (wr_step == $past(wr_step) + 2'd1) && $stable(wr_ptr));

   // R2: an idle write strobe changes neither pointer nor rotation
   a_r2_idle_hold: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wr_en_n |=> $stable(wr_ptr) && $stable(wr_step));

   // R4: an accepted read moves the read pointer by one
   a_r4_read_advance: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (ld_n && !rd_en_n && empty_n) |=> (rd_ptr == $past(rd_ptr) + 1'b1) && $stable(rd_step));

   // R7: full implies almost-full
   a_r7_full_afull: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> !afull_n);

   // R6: empty implies almost-empty
   a_r6_empty_aempty: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);

   // R8: a read-back advances the read rotation and leaves the read pointer alone
   a_r8_rb_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!ld_n && !rd_en_n) |=> (rd_step == $past(rd_step) + 2'd1) && $stable(rd_ptr));

   // R9: a write while full does not move the write pointer
   a_r9_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!full_n && ld_n && !wr_en_n) |=> $stable(wr_ptr));

   // R10: a read while empty does not move the read pointer
   a_r10_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n && ld_n && !rd_en_n) |=> $stable(rd_ptr));

endmodule

bind thresh_fifo thresh_fifo_chk #(.PTR_W(PTR_W)) u_chk (
   .wr_clk  (wr_clk),
   .rd_clk  (rd_clk),
   .rst_n   (rst_n),
   .ld_n    (ld_n),
   .wr_en_n (wr_en_n),
   .rd_en_n (rd_en_n),
   .full_n  (full_n),
   .afull_n (afull_n),
   .empty_n (empty_n),
   .aempty_n(aempty_n),
   .wr_ptr  (wr_ptr_bin),
   .rd_ptr  (rd_ptr_bin),
   .wr_step (wr_step),
   .rd_step (rd_step)
);

// File: tb/thresh_fifo_test.sv
`timescale 1ns/1ps
module thresh_fifo_test;

   localparam int CLK_PERIOD  = 10;
   localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
   localparam int DEPTH       = 512;

   logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic       ld_n = 1'b1, wr_en_n = 1'b1, rd_en_n = 1'b1;
   logic [8:0] wr_data = '0;
   logic [8:0] rd_data;
   logic       full_n, afull_n, empty_n, aempty_n;

   int checks = 0, fails = 0;
   int n_cur = 7, m_cur = 7;
   logic [8:0] q[$];

   always #(CLK_PERIOD/2)  wr_clk = ~wr_clk;
   always #(RCLK_PERIOD/2) rd_clk = ~rd_clk;

   thresh_fifo uut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ld_n(ld_n),
      .wr_en_n(wr_en_n), .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
      .rd_en_n(rd_en_n), .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
   );

   function automatic bit exp_empty_n(int c);           return c != 0;              endfunction
   function automatic bit exp_full_n(int c);            return c != DEPTH;          endfunction
   function automatic bit exp_aempty_n(int c, int n);   return c > n;               endfunction
   function automatic bit exp_afull_n(int c, int m);    return c < DEPTH - m;       endfunction
   function automatic int part_of(int v, int s);
      case (s)
         0: return v & 31;
         1: return (v >> 5) & 15;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic wr_word(input logic [8:0] d);
      @(negedge wr_clk); ld_n = 1'b1; wr_en_n = 1'b0; wr_data = d;
      @(negedge wr_clk); wr_en_n = 1'b1;
   endtask

   task automatic prog_part(input logic [8:0] d);
      @(negedge wr_clk); ld_n = 1'b0; wr_en_n = 1'b0; wr_data = d;
      @(negedge wr_clk); wr_en_n = 1'b1; ld_n = 1'b1;
   endtask

   task automatic rd_strobe(input bit rb);
      @(negedge rd_clk); ld_n = !rb; rd_en_n = 1'b0;
      @(negedge rd_clk); rd_en_n = 1'b1; ld_n = 1'b1;
   endtask

   task automatic wait_r(input int k); repeat (k) @(negedge rd_clk); endtask
   task automatic wait_w(input int k); repeat (k) @(negedge wr_clk); endtask

   task automatic check_readback(input int n, input int m, input string tag);
      int vals[4];
      vals[0] = part_of(n, 0); vals[1] = part_of(n, 1);
      vals[2] = part_of(m, 0); vals[3] = part_of(m, 1);
      for (int s = 0; s < 4; s++) begin
         rd_strobe(1'b1);
         chk(rd_data == 9'(vals[s]), tag, rd_data, vals[s]);
      end
   endtask

   task automatic check_rd_flags(input string tag);
      chk(empty_n == exp_empty_n(q.size()), {tag, " R5 empty_n"}, empty_n, exp_empty_n(q.size()));
      chk(aempty_n == exp_aempty_n(q.size(), n_cur), {tag, " R6 aempty_n"}, aempty_n,
          exp_aempty_n(q.size(), n_cur));
   endtask

   task automatic check_wr_flags(input string tag);
      chk(full_n == exp_full_n(q.size()), {tag, " R5 full_n"}, full_n, exp_full_n(q.size()));
      chk(afull_n == exp_afull_n(q.size(), m_cur), {tag, " R7 afull_n"}, afull_n,
          exp_afull_n(q.size(), m_cur));
   endtask

   task automatic pop_check(input string tag);
      logic [8:0] e;
      e = q.pop_front();
      rd_strobe(1'b0);
      chk(rd_data == e, {tag, " R4 data"}, rd_data, e);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [8:0] d;
      void'($urandom(32'd24680));
      wait_w(4);
      rst_n = 1'b1;
      wait_w(2);

      // R3 reset state
      chk(empty_n == 1'b0, "R3 empty_n", empty_n, 0);
      chk(aempty_n == 1'b0, "R3 aempty_n", aempty_n, 0);
      chk(full_n == 1'b1, "R3 full_n", full_n, 1);
      chk(afull_n == 1'b1, "R3 afull_n", afull_n, 1);
      chk(rd_data == 9'd0, "R3 rd_data", rd_data, 0);

      // R3/R8 default offsets, twice around to see the wrap
      check_readback(7, 7, "R3 R8 default readback");
      check_readback(7, 7, "R8 wrap readback");

      // R2: ld_n toggles with wr_en_n high change nothing
      for (int i = 0; i < 6; i++) begin
         @(negedge wr_clk); ld_n = i[0]; wr_data = 9'h1ff;
      end
      @(negedge wr_clk); ld_n = 1'b1;
      wait_r(6);
      chk(empty_n == 1'b0, "R2 no word stored", empty_n, 0);
      check_readback(7, 7, "R2 offsets unchanged");

      // R10: read while empty is ignored
      rd_strobe(1'b0);
      wr_word(9'h155); q.push_back(9'h155);
      wait_r(5);
      chk(empty_n == 1'b1, "R11 empty_n clears within four rd edges", empty_n, 1);
      pop_check("R10 after empty read");
      check_rd_flags("R10 drained");

      // fill to full, checking flags at every count
      for (int c = 1; c <= DEPTH; c++) begin
         d = 9'($urandom);
         wr_word(d); q.push_back(d);
         check_wr_flags("fill");
         if (c <= 12 || c >= DEPTH - 2) begin
            wait_r(6);
            check_rd_flags("fill");
         end
      end

      // R9: write while full is ignored
      wr_word(9'h0aa);
      chk(full_n == 1'b0, "R9 still full", full_n, 0);
      wait_r(6);

      // drain, checking data and read-side flags
      while (q.size() > 0) begin
         pop_check("drain");
         check_rd_flags("drain");
      end
      wait_w(6);
      check_wr_flags("drained");
      chk(empty_n == 1'b0, "R9 dropped word absent", empty_n, 0);

      // R1: eight loads; the second four land on the same registers
      for (int i = 0; i < 4; i++) prog_part(9'd1);
      n_cur = 20; m_cur = 300;
      prog_part(9'(part_of(n_cur, 0))); prog_part(9'(part_of(n_cur, 1)));
      prog_part(9'(part_of(m_cur, 0))); prog_part(9'(part_of(m_cur, 1)));
      wait_r(4);
      check_readback(n_cur, m_cur, "R1 R8 programmed readback");
      chk(empty_n == 1'b0, "R1 loads store no word", empty_n, 0);

      // flags with new thresholds across both edges
      for (int c = 1; c <= 230; c++) begin
         d = 9'($urandom);
         wr_word(d); q.push_back(d);
         check_wr_flags("R7 threshold fill");
         if ((c >= 18 && c <= 23) || (c >= 209 && c <= 214)) begin
            wait_r(6);
            check_rd_flags("R6 threshold fill");
         end
      end
      while (q.size() > 0) begin
         pop_check("threshold drain");
         check_rd_flags("threshold drain");
         if (q.size() >= 209 && q.size() <= 214) begin
            wait_w(6);
            check_wr_flags("R7 threshold drain");
         end
      end

      // R8: read-back leaves stored words alone
      wr_word(9'h0c3); q.push_back(9'h0c3);
      wr_word(9'h13c); q.push_back(9'h13c);
      wait_r(6);
      check_readback(n_cur, m_cur, "R8 readback with data held");
      pop_check("R8 data intact");
      pop_check("R8 data intact");

      // concurrent random traffic
      ld_n = 1'b1;
      fork
         begin
            for (int i = 0; i < 1500; i++) begin
               @(negedge wr_clk);
               if (($urandom % 3) != 0 && full_n) begin
                  d = 9'($urandom);
                  wr_data = d; wr_en_n = 1'b0; q.push_back(d);
               end else begin
                  wr_en_n = 1'b1;
               end
            end
            @(negedge wr_clk); wr_en_n = 1'b1;
         end
         begin
            logic [8:0] e;
            bit pend;
            pend = 1'b0; e = '0;
            for (int i = 0; i < 1200; i++) begin
               @(negedge rd_clk);
               if (pend) chk(rd_data == e, "R4 random order", rd_data, e);
               pend = 1'b0;
               if (($urandom % 2) != 0 && empty_n && q.size() > 0) begin
                  e = q.pop_front(); rd_en_n = 1'b0; pend = 1'b1;
               end else begin
                  rd_en_n = 1'b1;
               end
            end
            @(negedge rd_clk); rd_en_n = 1'b1;
            if (pend) chk(rd_data == e, "R4 random order", rd_data, e);
         end
      join
      wait_r(6);
      while (q.size() > 0) pop_check("random drain");
      check_rd_flags("final");
      wait_w(6);
      check_wr_flags("final");

      summary();
   end

endmodule